// File: doc/BRIEF.md
# Oscillator-Lane Random Source Controller

The block is the digital controller of a true random source built from a bank of free-running oscillator lanes, 24 by default. Each lane delivers one raw bit per clock on `lane_bit_i`. After a programmable startup delay, the controller samples the lanes at a programmable interval. On every sample tick it folds the bits of the lanes that are switched on into one bit with XOR. It shifts that bit into a 64-bit result. Once 64 bits are in, the result is offered as two 32-bit words and a ready flag is raised. Sampling pauses until software acknowledges the result.

In parallel, every lane is watched for a stuck or looping source. When a lane produces the same byte several times in a row, beyond a programmable limit, the lane raises an alarm. It is switched off and its bit is recorded in two lane-wide registers: a stop record and an event record. If more lanes are stopped than a programmable budget allows, a sticky overflow flag is set. To recover, software clears the records, flips the retune bits of the offending lanes, switches the lanes back on and acknowledges the flag. The retune mask is driven out on `lane_tune_o` so that the oscillators can change their behaviour. A soft reset register returns the whole block to its power-on state.

Registers are reached over a simple 32-bit write/read bus, and reads are combinational. The offsets are: 0x000 result low word, 0x004 result high word, 0x008 status, 0x010 acknowledge, 0x014 control, 0x018 refill interval, 0x01C alarm limits, 0x020 lane on, 0x024 lane retune, 0x028 alarm event record, 0x02C lane stop record, and 0x1FF0 soft reset.

Top module: `trng_ctrl`

## Requirements
- R1: Hard reset or soft reset leaves every register at 0, the status at 0 and both result words at 0. Writing 1 to bit 0 at 0x1FF0 starts a soft reset. That bit reads 1 for 8 cycles and then reads 0, with all registers restored to 0.
- R2: After control bit 10 rises, with the startup count S in control bits 31:16, no sample is taken during the first S+1 cycles. With sample period P, the ready flag (status bit 0) appears after S+1+64·P cycles.
- R3: The sample period P is the refill minimum in 0x018 bits 7:0, or 1 if that field is 0. It is then capped by the refill maximum in bits 31:16 when the maximum is nonzero and smaller.
- R4: Each tick shifts the XOR of (`lane_bit_i` AND lane-on mask) into bit 0 of the 64-bit result. Lanes that are switched off contribute 0. Bits 31:0 of the result read at 0x000 and bits 63:32 at 0x004.
- R5: While ready is set, no sample is taken and the result stays stable. Both result words read 0 while ready is clear. Writing 1 to bit 0 of 0x010 clears ready and starts a fresh 64-bit collection.
- R6: Each enabled lane compares each completed byte of its own bits with its previous byte. When the run of equal bytes exceeds the repeat limit in 0x01C bits 7:0, the lane's bit is set in 0x02C and 0x028 and cleared in 0x020. An equal run of exactly the limit raises no alarm.
- R7: While the number of set bits in 0x02C exceeds the lane budget in 0x01C bits 20:16, status bit 1 is set. It stays set until it is acknowledged by writing 1 to bit 1 of 0x010, and that acknowledge has no effect while the count still exceeds the budget.
- R8: The registers 0x028, 0x02C and 0x024 take the written value and read it back. Writing 0 clears them. The retune register also drives `lane_tune_o`.
- R9: `lane_run_o` mirrors the lane-on register at 0x020.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 13 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| lane_bit_i | input | N_LANES | Raw bit from each oscillator lane |
| lane_run_o | output | N_LANES | Per-lane run enable |
| lane_tune_o | output | N_LANES | Per-lane retune mask |

## Verification
The hardest state to reach from the ports is lane shutdown and budget overflow. With healthy lanes it almost never happens, because it needs a lane to repeat whole bytes for several byte periods in a row. The bench drives its lanes from seeded per-lane shift-register models but can force chosen lanes to a constant level. That makes every byte of those lanes identical, so the alarm falls on a byte boundary that can be computed. With the repeat limit at 0 or 2, the bench checks the stop and event records just before and just after that boundary. It then moves the lane budget across the stopped count and walks the recovery sequence to confirm the overflow flag clears.

// File: rtl/trng_pkg.sv
package trng_pkg;

    localparam int BUS_AW   = 13;
    localparam int BUS_DW   = 32;
    localparam int RESULT_W = 64;
    localparam int SAMPLE_W = 8;

    // Software-visible byte offsets
    localparam logic [BUS_AW-1:0] A_RES_LO = 13'h0000;
    localparam logic [BUS_AW-1:0] A_RES_HI = 13'h0004;
    localparam logic [BUS_AW-1:0] A_STATUS = 13'h0008;
    localparam logic [BUS_AW-1:0] A_ACK    = 13'h0010;
    localparam logic [BUS_AW-1:0] A_CTL    = 13'h0014;
    localparam logic [BUS_AW-1:0] A_REFILL = 13'h0018;
    localparam logic [BUS_AW-1:0] A_LIMITS = 13'h001C;
    localparam logic [BUS_AW-1:0] A_LANEON = 13'h0020;
    localparam logic [BUS_AW-1:0] A_TUNE   = 13'h0024;
    localparam logic [BUS_AW-1:0] A_EVENT  = 13'h0028;
    localparam logic [BUS_AW-1:0] A_STOP   = 13'h002C;
    localparam logic [BUS_AW-1:0] A_SRST   = 13'h1FF0;

    localparam int ST_READY = 0;
    localparam int ST_OVF   = 1;
    localparam int CTL_RUN  = 10;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_RES_LO, SEL_RES_HI, SEL_STATUS, SEL_ACK, SEL_CTL,
        SEL_REFILL, SEL_LIMITS, SEL_LANEON, SEL_TUNE, SEL_EVENT, SEL_STOP,
        SEL_SRST
    } reg_sel_e;

    typedef struct packed {
        logic [15:0] startup;
        logic        run;
        logic [15:0] refill_max;
        logic [7:0]  refill_min;
        logic [7:0]  rep_limit;
        logic [4:0]  stop_limit;
    } cfg_t;

    function automatic reg_sel_e decode_addr(input logic [BUS_AW-1:0] a);
        reg_sel_e s;
        case (a)
            A_RES_LO: s = SEL_RES_LO;
            A_RES_HI: s = SEL_RES_HI;
            A_STATUS: s = SEL_STATUS;
            A_ACK:    s = SEL_ACK;
            A_CTL:    s = SEL_CTL;
            A_REFILL: s = SEL_REFILL;
            A_LIMITS: s = SEL_LIMITS;
            A_LANEON: s = SEL_LANEON;
            A_TUNE:   s = SEL_TUNE;
            A_EVENT:  s = SEL_EVENT;
            A_STOP:   s = SEL_STOP;
            A_SRST:   s = SEL_SRST;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    // R3: minimum (0 treated as 1), capped by a nonzero smaller maximum
    function automatic logic [15:0] sample_period(input logic [7:0] lo, input logic [15:0] hi);
        logic [15:0] p;
        p = (lo == 8'd0) ? 16'd1 : {8'd0, lo};
        if (hi != 16'd0 && hi < p) p = hi;
        return p;
    endfunction

endpackage

// File: rtl/trng_pacer.sv
module trng_pacer (
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        hold,
    input  logic [15:0] startup,
    input  logic [15:0] period,
    output logic        tick
);
    logic        run_d;
    logic [15:0] wait_q;
    logic [15:0] ivl_q;
    logic        start;
    logic        going;

    assign start = run & ~run_d;
    assign going = run & ~start & (wait_q == 16'd0) & ~hold;
    assign tick  = going & (ivl_q >= period - 16'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_d  <= 1'b0;
            wait_q <= '0;
            ivl_q  <= '0;
        end else begin
            run_d <= run;
            if (start) begin
                wait_q <= startup;   // R2: startup window loads on the enable edge
                ivl_q  <= '0;
            end else if (run && wait_q != 16'd0) begin
                wait_q <= wait_q - 16'd1;
            end else if (going) begin
                ivl_q <= tick ? 16'd0 : ivl_q + 16'd1;
            end
        end
    end
endmodule

// File: rtl/trng_lane_watch.sv
module trng_lane_watch
    import trng_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                byte_end,
    input  logic                lane_bit,
    input  logic                lane_on,
    input  logic [SAMPLE_W-1:0] limit,
    output logic                alarm
);
    logic [SAMPLE_W-2:0] part_q;
    logic [SAMPLE_W-1:0] prev_q;
    logic [SAMPLE_W-1:0] rep_q;
    logic                prev_ok_q;
    logic [SAMPLE_W-1:0] sample;
    logic [SAMPLE_W:0]   rep_inc;
    logic                same;

    assign sample  = {part_q, lane_bit};
    assign same    = prev_ok_q && (sample == prev_q);
    assign rep_inc = {1'b0, rep_q} + 1'b1;
    // R6: alarm once the run of equal bytes goes past the limit
    assign alarm   = byte_end && lane_on && same && (rep_inc > {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q    <= '0;
            prev_q    <= '0;
            rep_q     <= '0;
            prev_ok_q <= 1'b0;
        end else if (!lane_on) begin
            prev_ok_q <= 1'b0;
            rep_q     <= '0;
        end else if (byte_end) begin
            prev_q <= sample;
            if (alarm) begin
                prev_ok_q <= 1'b0;
                rep_q     <= '0;
            end else begin
                prev_ok_q <= 1'b1;
                rep_q     <= same ? rep_inc[SAMPLE_W-1:0] : '0;
            end
        end else if (tick) begin
            part_q <= {part_q[SAMPLE_W-3:0], lane_bit};
        end
    end
endmodule

// File: rtl/trng_harvest.sv
module trng_harvest
    import trng_pkg::*;
#(
    parameter int N_LANES = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ack,
    input  logic                flush,
    input  logic                tick,
    input  logic [N_LANES-1:0]  lane_bits,
    input  logic [N_LANES-1:0]  lane_mask,
    output logic                ready,
    output logic                byte_end,
    output logic [RESULT_W-1:0] word
);
    localparam int CW = $clog2(RESULT_W);
    localparam logic [CW-1:0] LAST = CW'(RESULT_W - 1);

    logic [RESULT_W-1:0] shreg_q;
    logic [CW-1:0]       cnt_q;
    logic                fold;

    assign fold     = ^(lane_bits & lane_mask);          // R4
    assign byte_end = tick && (cnt_q[2:0] == 3'h7);
    assign word     = ready ? shreg_q : '0;              // R5

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            ready   <= 1'b0;
        end else if (ack) begin
            ready <= 1'b0;
            cnt_q <= '0;
        end else if (flush) begin
            cnt_q <= '0;
        end else if (tick) begin
            shreg_q <= {shreg_q[RESULT_W-2:0], fold};
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST) ready <= 1'b1;
        end
    end

    assert_idle_when_ready_R5: assert property (@(posedge clk) disable iff (rst)
        ready |-> !tick);
    assert_ready_needs_tick_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(tick));
endmodule

// File: rtl/trng_ctrl.sv
module trng_ctrl
    import trng_pkg::*;
#(
    parameter int N_LANES         = 24,
    parameter int SOFT_RST_CYCLES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [12:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N_LANES-1:0] lane_bit_i,
    output logic [N_LANES-1:0] lane_run_o,
    output logic [N_LANES-1:0] lane_tune_o
);
    localparam int SRW = $clog2(SOFT_RST_CYCLES + 1);
    localparam int PAD = BUS_DW - N_LANES;

    logic [SRW-1:0]      srst_q;
    logic                busy;
    logic                rst_int;
    reg_sel_e            sel;
    cfg_t                cfg_q, cfg_n;
    logic [N_LANES-1:0]  on_q, on_n, tune_q, tune_n, evt_q, evt_n, stop_q, stop_n;
    logic                ovf_q, ovf_n;
    logic [N_LANES-1:0]  alarm_v;
    logic                over;
    logic                ack_res, ack_ovf;
    logic                tick, ready, byte_end;
    logic [RESULT_W-1:0] word;

    assign sel     = decode_addr(bus_addr);
    assign busy    = (srst_q != '0);
    assign rst_int = rst | busy;
    assign ack_res = bus_wr && sel == SEL_ACK && bus_wdata[ST_READY];
    assign ack_ovf = bus_wr && sel == SEL_ACK && bus_wdata[ST_OVF];
    assign over    = $countones(stop_q) > int'(cfg_q.stop_limit);

    // R1: soft reset sequencer, outside the reset it drives
    always_ff @(posedge clk) begin
        if (rst)                                             srst_q <= '0;
        else if (busy)                                       srst_q <= srst_q - 1'b1;
        else if (bus_wr && sel == SEL_SRST && bus_wdata[0])  srst_q <= SRW'(SOFT_RST_CYCLES);
    end

    always_comb begin
        cfg_n  = cfg_q;
        on_n   = on_q;
        tune_n = tune_q;
        evt_n  = evt_q;
        stop_n = stop_q;
        if (bus_wr) begin
            case (sel)
                SEL_CTL: begin
                    cfg_n.startup = bus_wdata[31:16];
                    cfg_n.run     = bus_wdata[CTL_RUN];
                end
                SEL_REFILL: begin
                    cfg_n.refill_max = bus_wdata[31:16];
                    cfg_n.refill_min = bus_wdata[7:0];
                end
                SEL_LIMITS: begin
                    cfg_n.stop_limit = bus_wdata[20:16];
                    cfg_n.rep_limit  = bus_wdata[7:0];
                end
                SEL_LANEON: on_n   = bus_wdata[N_LANES-1:0];
                SEL_TUNE:   tune_n = bus_wdata[N_LANES-1:0];
                SEL_EVENT:  evt_n  = bus_wdata[N_LANES-1:0];
                SEL_STOP:   stop_n = bus_wdata[N_LANES-1:0];
                default: ;
            endcase
        end
        // R6: an alarm overrides a same-cycle write
        on_n   = on_n & ~alarm_v;
        evt_n  = evt_n | alarm_v;
        stop_n = stop_n | alarm_v;
        // R7: set wins over acknowledge
        ovf_n  = (ovf_q & ~ack_ovf) | over;
    end

    always_ff @(posedge clk) begin
        if (rst_int) begin
            cfg_q  <= '0;
            on_q   <= '0;
            tune_q <= '0;
            evt_q  <= '0;
            stop_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            cfg_q  <= cfg_n;
            on_q   <= on_n;
            tune_q <= tune_n;
            evt_q  <= evt_n;
            stop_q <= stop_n;
            ovf_q  <= ovf_n;
        end
    end

    assign lane_run_o  = on_q;     // R9
    assign lane_tune_o = tune_q;   // R8

    trng_pacer u_pacer (
        .clk     (clk),
        .rst     (rst_int),
        .run     (cfg_q.run),
        .hold    (ready),
        .startup (cfg_q.startup),
        .period  (sample_period(cfg_q.refill_min, cfg_q.refill_max)),
        .tick    (tick)
    );

    trng_harvest #(.N_LANES(N_LANES)) u_harvest (
        .clk       (clk),
        .rst       (rst_int),
        .ack       (ack_res),
        .flush     (~cfg_q.run),
        .tick      (tick),
        .lane_bits (lane_bit_i),
        .lane_mask (on_q),
        .ready     (ready),
        .byte_end  (byte_end),
        .word      (word)
    );

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        trng_lane_watch u_watch (
            .clk      (clk),
            .rst      (rst_int),
            .tick     (tick),
            .byte_end (byte_end),
            .lane_bit (lane_bit_i[i]),
            .lane_on  (on_q[i]),
            .limit    (cfg_q.rep_limit),
            .alarm    (alarm_v[i])
        );
    end

    always_comb begin
        case (sel)
            SEL_RES_LO: bus_rdata = word[31:0];
            SEL_RES_HI: bus_rdata = word[63:32];
            SEL_STATUS: bus_rdata = {30'd0, ovf_q, ready};
            SEL_CTL:    bus_rdata = {cfg_q.startup, 5'd0, cfg_q.run, 10'd0};
            SEL_REFILL: bus_rdata = {cfg_q.refill_max, 8'd0, cfg_q.refill_min};
            SEL_LIMITS: bus_rdata = {11'd0, cfg_q.stop_limit, 8'd0, cfg_q.rep_limit};
            SEL_LANEON: bus_rdata = {{PAD{1'b0}}, on_q};
            SEL_TUNE:   bus_rdata = {{PAD{1'b0}}, tune_q};
            SEL_EVENT:  bus_rdata = {{PAD{1'b0}}, evt_q};
            SEL_STOP:   bus_rdata = {{PAD{1'b0}}, stop_q};
            SEL_SRST:   bus_rdata = {31'd0, busy};
            default:    bus_rdata = '0;
        endcase
    end

    assert_alarm_stops_lane_R6: assert property (@(posedge clk) disable iff (rst_int)
        (|alarm_v) |=> ((on_q & $past(alarm_v)) == '0));
    assert_alarm_recorded_R6: assert property (@(posedge clk) disable iff (rst_int)
        (|alarm_v) |=> ((stop_q & $past(alarm_v)) == $past(alarm_v)));
    assert_overflow_flag_R7: assert property (@(posedge clk) disable iff (rst_int)
        over |=> ovf_q);
    assert_ack_releases_R5: assert property (@(posedge clk) disable iff (rst_int)
        ack_res |=> !ready);
endmodule

// File: tb/trng_ctrl_bench.sv
module trng_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [12:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  lane_bit_i;
    logic [N-1:0]  lane_run_o;
    logic [N-1:0]  lane_tune_o;

    logic [N-1:0]  force_m = '0;
    logic [N-1:0]  force_v = '0;
    logic [15:0]   lfsr [N];
    logic [N-1:0]  tune_seen;

    int total = 0;
    int bad = 0;

    // en mask, forced levels, expected 64-bit result
    localparam logic [111:0] VECS [6] = '{
        {24'h000001, 24'h000001, 64'hFFFF_FFFF_FFFF_FFFF},
        {24'h000003, 24'h000003, 64'h0000_0000_0000_0000},
        {24'h000007, 24'hFFFFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        {24'h000000, 24'hFFFFFF, 64'h0000_0000_0000_0000},
        {24'hF00000, 24'h100000, 64'hFFFF_FFFF_FFFF_FFFF},
        {24'h000002, 24'hFFFFFD, 64'h0000_0000_0000_0000}
    };

    trng_ctrl #(.N_LANES(N)) u_trng_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lane_bit_i(lane_bit_i),
        .lane_run_o(lane_run_o), .lane_tune_o(lane_tune_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] seed_of(input int i, input logic t);
        return {8'(i + 1), 8'hA5} ^ (t ? 16'h5A00 : 16'h0000);
    endfunction

    // seeded per-lane oscillator stand-ins; retune reseeds a lane
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst || lane_tune_o[i] != tune_seen[i])
                lfsr[i] <= seed_of(i, lane_tune_o[i]);
            else
                lfsr[i] <= lfsr[i][0] ? ((lfsr[i] >> 1) ^ 16'hB400) : (lfsr[i] >> 1);
        end
        tune_seen <= lane_tune_o;
    end

    always_comb begin
        for (int i = 0; i < N; i++)
            lane_bit_i[i] = force_m[i] ? force_v[i] : lfsr[i][0];
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [12:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_ready(output int n);
        logic [31:0] s;
        n = 0;
        for (int k = 0; k < 20000; k++) begin
            peek(13'h008, s);
            if (s[0]) break;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic soft_reset();
        bus_write(13'h1FF0, 32'h1);
        idle(12);
    endtask

    function automatic logic [31:0] ctl_word(input logic [15:0] s);
        return {s, 5'd0, 1'b1, 10'd0};
    endfunction

    task automatic timed_run(input logic [15:0] s, input logic [7:0] mn,
                             input logic [15:0] mx, output int n);
        bus_write(13'h014, 32'h0);
        bus_write(13'h018, {mx, 8'd0, mn});
        bus_write(13'h010, 32'h1);
        bus_write(13'h014, ctl_word(s));
        wait_ready(n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d, lo, hi;
        logic [63:0] r1, r2;
        int n;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);

        // R1: power-on state
        peek(13'h008, d); check("R1 status", d, 0);
        peek(13'h000, d); check("R1 result lo", d, 0);
        peek(13'h014, d); check("R1 control", d, 0);
        check("R1 lane ports", {lane_run_o, lane_tune_o}, 0);

        // R1: soft reset
        bus_write(13'h018, 32'h0022_0021);
        bus_write(13'h020, 32'h00ABCD);
        bus_write(13'h1FF0, 32'h1);
        peek(13'h1FF0, d); check("R1 soft reset busy", d, 1);
        idle(10);
        peek(13'h1FF0, d); check("R1 soft reset done", d, 0);
        peek(13'h018, d);  check("R1 refill cleared", d, 0);
        peek(13'h020, d);  check("R1 lane-on cleared", d, 0);

        // R8 / R9
        bus_write(13'h01C, {11'd0, 5'd31, 8'd0, 8'd255});
        bus_write(13'h024, 32'h0000A5);
        peek(13'h024, d); check("R8 retune readback", d, 32'hA5);
        check("R8 retune port", lane_tune_o, 24'hA5);
        bus_write(13'h020, 32'hFFFFFF);
        check("R9 run port", lane_run_o, 24'hFFFFFF);

        // R5: normal collection with model lanes
        bus_write(13'h014, ctl_word(16'd0));
        wait_ready(n);
        peek(13'h000, lo); peek(13'h004, hi); r1 = {hi, lo};
        idle(20);
        peek(13'h000, lo); peek(13'h004, hi);
        check("R5 result stable while ready", {hi, lo}, r1);
        bus_write(13'h010, 32'h1);
        peek(13'h008, d); check("R5 ack clears ready", d[0], 0);
        peek(13'h000, d); check("R5 result zero when not ready", d, 0);
        wait_ready(n);
        peek(13'h000, lo); peek(13'h004, hi); r2 = {hi, lo};
        check("R5 second result differs", (r1 == r2) ? 1 : 0, 0);

        // R2 / R3: timing
        timed_run(16'd20, 8'd1, 16'd0, n);
        check_range("R2 startup latency", n, 20 + 64, 20 + 66);
        timed_run(16'd0, 8'd3, 16'd0, n);
        check_range("R3 period from minimum", n, 192, 194);
        timed_run(16'd0, 8'd10, 16'd2, n);
        check_range("R3 period capped by maximum", n, 128, 130);
        timed_run(16'd0, 8'd0, 16'd0, n);
        check_range("R3 zero minimum means 1", n, 64, 66);

        // R4: fold vectors with forced lanes
        force_m = '1;
        for (int v = 0; v < 6; v++) begin
            bus_write(13'h014, 32'h0);
            bus_write(13'h020, {8'd0, VECS[v][111:88]});
            force_v = VECS[v][87:64];
            bus_write(13'h010, 32'h1);
            bus_write(13'h014, ctl_word(16'd0));
            wait_ready(n);
            peek(13'h000, lo); peek(13'h004, hi);
            check($sformatf("R4 fold vector %0d", v), {hi, lo}, VECS[v][63:0]);
        end

        // R6: single stuck lane, repeat limit 2
        soft_reset();
        force_m = 24'h000020; force_v = 24'h000020;
        bus_write(13'h01C, {11'd0, 5'd31, 8'd0, 8'd2});
        bus_write(13'h020, 32'h00002F);
        bus_write(13'h014, ctl_word(16'd0));
        idle(28);
        peek(13'h02C, d); check("R6 no alarm at limit", d, 0);
        idle(12);
        peek(13'h02C, d); check("R6 stop record", d, 32'h20);
        peek(13'h028, d); check("R6 event record", d, 32'h20);
        check("R6 lane switched off", lane_run_o, 24'h00000F);

        // R7: two stuck lanes, limit 0
        soft_reset();
        force_m = 24'h000060; force_v = 24'h000020;
        bus_write(13'h01C, {11'd0, 5'd2, 8'd0, 8'd0});
        bus_write(13'h020, 32'h000060);
        bus_write(13'h014, ctl_word(16'd0));
        idle(40);
        peek(13'h02C, d); check("R7 both lanes stopped", d, 32'h60);
        peek(13'h008, d); check("R7 no overflow at budget", d[1], 0);
        bus_write(13'h01C, {11'd0, 5'd1, 8'd0, 8'd0});
        idle(1);
        peek(13'h008, d); check("R7 overflow over budget", d[1], 1);
        bus_write(13'h010, 32'h2);
        idle(1);
        peek(13'h008, d); check("R7 ack ignored while over", d[1], 1);
        bus_write(13'h014, 32'h0);
        peek(13'h02C, d);
        bus_write(13'h028, 32'h0);
        bus_write(13'h02C, 32'h0);
        bus_write(13'h024, d ^ 32'h0);
        bus_write(13'h020, 32'hFFFFFF);
        bus_write(13'h010, 32'h2);
        idle(1);
        peek(13'h008, d); check("R7 overflow cleared", d[1], 0);
        peek(13'h028, d); check("R8 event cleared by write 0", d, 0);
        peek(13'h02C, d); check("R8 stop cleared by write 0", d, 0);
        check("R8 retune port after recovery", lane_tune_o, 24'h60);
        check("R9 lanes back on", lane_run_o, 24'hFFFFFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule